// File: doc/BRIEF.md
# Fan Voltage Command Target on a Two-Wire Bus

This block is a fixed-address SMBus/I2C target. It supports exactly two transfers: a one-byte write that sets a fan voltage command, and a one-byte read that returns two fault flags. SCL and SDA are sampled with the system clock. The block never drives a bus line high. It pulls SDA low through an open-drain enable (`sda_oe`), and the pad drives the line low while that enable is 1.

A write carries a six-bit output code and a boost-start enable. The pair is held in a command register. That register changes only as the target finishes acknowledging the command byte, so a transfer cut short by a stop or a repeated start leaves the old setting in place. A read returns the over-current and thermal-shutdown flags, which arrive from outside as plain logic levels. The bus never stalls: there is no clock stretching and no handshake at the block's edge. The command register outputs are plain levels that a downstream DAC can use directly.

Top module: `fanbus_target`

## Requirements
- R1: While reset is asserted, `fan_code` is 0, `boost_en` is 0 and `sda_oe` is 0.
- R2: The target address is 7'b1110100, received MSB first. It is followed by a direction bit: 0 selects write, 1 selects read. A matching address is acknowledged by holding SDA low through the ninth SCL high phase.
- R3: After any other address, the target leaves SDA released for the rest of the transfer and ignores the bus until the next start. A write to a wrong address leaves the command register unchanged, and a read from a wrong address sees all ones.
- R4: In a write, the target acknowledges the command byte (MSB first) on the eighteenth clock. Bits 5..0 then become `fan_code` (bit 5 is the MSB) and bit 6 becomes `boost_en`. Bit 7 has no effect.
- R5: The command register keeps its previous value through the high phase of the command acknowledge clock. It takes the new value only after that clock falls.
- R6: A stop that arrives before the command acknowledge has completed (during the command bits, or right after the address acknowledge) leaves the command register unchanged.
- R7: In a read, the target drives the byte {over-current flag, thermal flag, 6'b000000} MSB first, one bit per clock. A read does not change the command register.
- R8: The target releases SDA for the host's acknowledge clock after the read byte, and for the clocks that follow it. This holds whether the host sends a not-acknowledge or an acknowledge.
- R9: A start seen in the middle of a transfer (SDA falling while SCL is high) drops the partial byte and begins address reception again.
- R10: The target pulls SDA low only in acknowledge slots and read data bits, so a 1 written by the host is never overridden. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on / undervoltage) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| ovc_flag | input | 1 | Over-current fault level |
| therm_flag | input | 1 | Thermal-shutdown fault level |
| boost_en | output | 1 | Committed boost-start enable |
| fan_code | output | CODE_W | Committed output code |

## Verification
The assertions assume that every SCL high phase and every SCL low phase lasts longer than the synchronizer plus edge-detect latency of three clocks. They also assume that the host changes SDA only while SCL is low, except when it signals a start or a stop. Under those assumptions, the enable moves only on a detected falling edge, so it stays stable while SCL is high. The bench keeps each SCL phase at eight clocks and each setup or hold gap at four clocks. It changes data only in the middle of the low phase, so every transfer stays inside these assumptions.

// File: rtl/fanbus_pkg.sv
package fanbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CMD,
    ST_CACK,
    ST_TX,
    ST_TACK
  } bus_state_t;
endpackage

// File: rtl/fanbus_sync.sv
module fanbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/fanbus_engine.sv
module fanbus_engine
  import fanbus_pkg::*;
#(
  parameter int               CODE_W = 6,
  parameter logic [CODE_W:0]  TARGET_ADDR = 7'b1110100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              ovc_flag,
  input  logic              therm_flag,
  output logic              sda_oe,
  output logic              boost_en,
  output logic [CODE_W-1:0] fan_code
);
  localparam int BYTE_W = CODE_W + 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  bus_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              is_read;
  logic              start_c;
  logic              stop_c;

  assign start_c = scl_lvl & sda_fall;
  assign stop_c  = scl_lvl & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txreg    <= '0;
      is_read  <= 1'b0;
      sda_oe   <= 1'b0;
      boost_en <= 1'b0;
      fan_code <= '0;
    end else if (start_c) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD: begin
          if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            cnt <= '0;
            if (state == ST_CMD) begin
              sda_oe <= 1'b1;
              state  <= ST_CACK;
            end else if (shreg[BYTE_W-1:1] == TARGET_ADDR) begin
              sda_oe  <= 1'b1;
              is_read <= shreg[0];
              state   <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (is_read) begin
              txreg  <= {ovc_flag, therm_flag, {CODE_W{1'b0}}};
              sda_oe <= ~ovc_flag;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
        end
        ST_CACK: begin
          if (scl_fall) begin
            sda_oe   <= 1'b0;
            boost_en <= shreg[CODE_W];
            fan_code <= shreg[CODE_W-1:0];
            state    <= ST_IDLE;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CNT_FULL) begin
              sda_oe <= 1'b0;
              state  <= ST_TACK;
            end else begin
              txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~txreg[BYTE_W-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fanbus_target.sv
module fanbus_target #(
  parameter int              CODE_W      = 6,
  parameter logic [CODE_W:0] TARGET_ADDR = 7'b1110100,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              ovc_flag,
  input  logic              therm_flag,
  output logic              boost_en,
  output logic [CODE_W-1:0] fan_code
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] fall;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    fanbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .lvl  (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  fanbus_engine #(.CODE_W(CODE_W), .TARGET_ADDR(TARGET_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (lvl[0]),
    .scl_rise  (rise[0]),
    .scl_fall  (fall[0]),
    .sda_lvl   (lvl[1]),
    .sda_rise  (rise[1]),
    .sda_fall  (fall[1]),
    .ovc_flag  (ovc_flag),
    .therm_flag(therm_flag),
    .sda_oe    (sda_oe),
    .boost_en  (boost_en),
    .fan_code  (fan_code)
  );
endmodule

// File: rtl/fanbus_checker.sv
module fanbus_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              boost_en,
  input logic [CODE_W-1:0] fan_code
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    ($past(rst_n) == 1'b0) |-> (fan_code == '0 && !boost_en && !sda_oe));

  assert_drive_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_commit_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fan_code) || !$stable(boost_en)) |-> ($past(sda_oe) && !sda_oe && !scl_i));

  assert_oe_quiet_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));
endmodule

bind fanbus_target fanbus_checker #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .boost_en(boost_en),
  .fan_code(fan_code)
);

// File: tb/fanbus_target_test.sv
module fanbus_target_test;
  localparam int Q = 4;
  localparam logic [6:0] MY_ADDR = 7'b1110100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       host_sda = 1'b1;
  logic       ovc = 1'b0;
  logic       therm = 1'b0;
  logic       sda_oe;
  logic       boost_en;
  logic [5:0] fan_code;
  wire        sda_line = host_sda & ~sda_oe;

  int total = 0;
  int bad = 0;
  logic       exp_boost = 1'b0;
  logic [5:0] exp_code = '0;

  always #10 clk = ~clk;

  fanbus_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .ovc_flag(ovc), .therm_flag(therm), .boost_en(boost_en), .fan_code(fan_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    host_sda = 1'b1; wq(); scl = 1'b1; wq(); host_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bstop();
    host_sda = 1'b0; wq(); scl = 1'b1; wq(); host_sda = 1'b1; wq();
  endtask

  task automatic wbit(input logic b);
    host_sda = b; wq(); scl = 1'b1; wq();
    if (b) chk("R10 host one kept", sda_line, 1);
    wq(); scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    host_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
  endtask

  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] c,
                          output logic ack_a, output logic ack_c, output logic [6:0] mid);
    bstart();
    wbyte({a, 1'b0});
    rbit(ack_a);
    wbyte(c);
    host_sda = 1'b1; wq(); scl = 1'b1; wq();
    ack_c = sda_line; mid = {boost_en, fan_code};
    wq(); scl = 1'b0; wq();
    bstop();
  endtask

  task automatic chk_cmd(input string req);
    chk(req, {boost_en, fan_code}, {exp_boost, exp_code});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic aa, ac, b;
    logic [6:0] mid;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R1 code in reset", fan_code, 0);
    chk("R1 boost in reset", boost_en, 0);
    chk("R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    wq();

    // R4/R5/R2: every command byte value written to the target
    for (int v = 0; v < 256; v++) begin
      do_write(MY_ADDR, 8'(v), aa, ac, mid);
      chk("R2 address ack", aa, 0);
      chk("R4 command ack", ac, 0);
      chk("R5 old value during ack", mid, {exp_boost, exp_code});
      exp_boost = v[6];
      exp_code = v[5:0];
      chk_cmd("R4 command committed");
    end

    // R3: every address with write direction
    for (int a = 0; a < 128; a++) begin
      logic [7:0] c;
      c = {1'b1, ~exp_boost, ~exp_code};
      do_write(7'(a), c, aa, ac, mid);
      if (7'(a) == MY_ADDR) begin
        chk("R2 match ack", aa, 0);
        exp_boost = c[6];
        exp_code = c[5:0];
        chk_cmd("R4 match commit");
      end else begin
        chk("R3 no address ack", aa, 1);
        chk("R3 no command ack", ac, 1);
        chk_cmd("R3 mismatch ignored");
      end
    end

    // R7/R8: read all flag pairs with host nack and host ack
    for (int f = 0; f < 8; f++) begin
      ovc = f[1]; therm = f[0];
      bstart();
      wbyte({MY_ADDR, 1'b1});
      rbit(aa);
      chk("R2 read address ack", aa, 0);
      rbyte(d);
      chk("R7 status byte", d, {f[1], f[0], 6'b0});
      wbit(f[2] ? 1'b0 : 1'b1);
      rbit(b);
      chk("R8 released after host ack slot", b, 1);
      bstop();
      chk_cmd("R7 read leaves command");
    end

    // R3: read from wrong address sees ones
    ovc = 1'b1; therm = 1'b1;
    bstart();
    wbyte({7'b1110101, 1'b1});
    rbit(aa);
    chk("R3 read mismatch no ack", aa, 1);
    rbyte(d);
    chk("R3 read mismatch data", d, 8'hFF);
    wbit(1'b1);
    bstop();

    // R6: stop inside command bits
    bstart();
    wbyte({MY_ADDR, 1'b0});
    rbit(aa);
    for (int i = 0; i < 5; i++) wbit(~exp_code[i % 6]);
    bstop();
    chk_cmd("R6 stop mid command");
    // R6: stop right after address ack
    bstart();
    wbyte({MY_ADDR, 1'b0});
    rbit(aa);
    bstop();
    chk_cmd("R6 stop after address");

    // R9: repeated start inside command byte, then a full write
    bstart();
    wbyte({MY_ADDR, 1'b0});
    rbit(aa);
    for (int i = 0; i < 3; i++) wbit(1'b1);
    do_write(MY_ADDR, 8'h15, aa, ac, mid);
    chk("R9 ack after restart", {aa, ac}, 0);
    exp_boost = 1'b0; exp_code = 6'h15;
    chk_cmd("R9 restart commit");
    // R9: repeated start inside address, then a full write
    bstart();
    for (int i = 0; i < 4; i++) wbit(MY_ADDR[6 - i]);
    do_write(MY_ADDR, 8'h6A, aa, ac, mid);
    chk("R9 ack after address restart", {aa, ac}, 0);
    exp_boost = 1'b1; exp_code = 6'h2A;
    chk_cmd("R9 address restart commit");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule